// File: doc/BRIEF.md
# Debug Breakpoint and Trap Unit

This unit sits next to a simple processor pipeline and decides when a debug exception is due. It holds four programmable breakpoint address registers, a control register and a sticky status register. On each cycle it compares the address of the instruction about to execute and the address of any data access against the enabled breakpoints. It also watches for the one-byte software breakpoint opcode 0xCC at fetch, and for the single-step flag when an instruction retires.

When any of these conditions holds, the unit raises a single exception request one cycle later. The request carries a vector number and a flag that marks it as a fault or a trap. Address breakpoints and single-step use vector 1, and the breakpoint opcode uses vector 3. Vector 1 wins when both occur in the same cycle. Software reads and writes the six registers through a 32-bit port with a 3-bit select.

Top module: `dbg_trap_unit`

## Requirements
- R1: After reset, every register reads 0, all breakpoints are disabled and `exc_req_o`, `exc_vec_o` and `exc_fault_o` are 0.
- R2: Select values 0 to 3 access the address registers, 4 the status register and 5 the control register, and reads are combinational. Select values 6 and 7 read 0, and writes to them change nothing.
- R3: Breakpoint i is configured by fields of the control register: enable at bit i, type at bits [9+4i:8+4i] and length at bits [11+4i:10+4i]. When an enabled execute-type breakpoint (type 00) has a register equal to `fetch_addr_i` while `fetch_valid_i` is high, the next cycle shows `exc_req_o`=1, vector 1 and `exc_fault_o`=1, and status bit i is set.
- R4: A type 01 breakpoint matches data writes only (`data_we_i`=1). A type 11 breakpoint matches data reads and writes. A type 10 breakpoint never matches. A data match gives vector 1 with `exc_fault_o`=0 and sets status bit i.
- R5: A length field of 00 compares all address bits, 01 ignores address bit 0, and 10 or 11 ignores address bits 1:0.
- R6: A breakpoint whose enable bit is clear never raises a request and never sets its status bit, whatever its type, length and address.
- R7: A retiring instruction (`retire_valid_i`) with bit 8 of `retire_flags_i` set gives vector 1 as a trap in the next cycle and sets status bit 4.
- R8: A valid fetch of opcode 0xCC gives vector 3 as a trap in the next cycle and sets no status bit.
- R9: When several conditions occur in one cycle, the unit issues one request and sets every matching status bit. The vector is 1 if any vector-1 condition is present, otherwise 3. `exc_fault_o` is 1 only if an execute breakpoint matched. With no request, the vector reads 0.
- R10: Status bits stay set until software writes the status register. If a write and a new hit fall in the same cycle, the hit's bit is set after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| fetch_valid_i | input | 1 | An instruction is about to execute |
| fetch_addr_i | input | 32 | Address of that instruction |
| fetch_opcode_i | input | 8 | First opcode byte of that instruction |
| data_valid_i | input | 1 | Data access this cycle |
| data_we_i | input | 1 | Data access is a write |
| data_addr_i | input | 32 | Data access address |
| retire_valid_i | input | 1 | An instruction completes this cycle |
| retire_flags_i | input | 32 | Flags word at completion (bit 8 = single step) |
| exc_req_o | output | 1 | Debug exception request |
| exc_vec_o | output | 8 | Exception vector (1 or 3, 0 when idle) |
| exc_fault_o | output | 1 | Request is a fault (execute breakpoint) |

## Verification
The bench targets the type encodings that separate write-only from read/write matching, and the reserved type. A design that mixes these up raises a request on a data read that should pass. It also targets the length masks at the edge of their alignment. A design that masks the wrong bits misses a hit one byte inside a word, or fires on the next word. Coincident conditions are driven in one cycle, so a design that lets vector 3 override vector 1, or that flags a data hit as a fault, shows a wrong vector or fault bit. A status write that lands together with a new hit checks that clearing does not swallow the fresh bit.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned VEC_W     = 8;
  localparam int unsigned CFG_LSB   = 8;
  localparam int unsigned CFG_PITCH = 4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd5;
  localparam logic [VEC_W-1:0] VEC_DBG  = 8'd1;
  localparam logic [VEC_W-1:0] VEC_BRK  = 8'd3;

  typedef enum logic [1:0] {
    BT_EXEC = 2'b00,
    BT_WR   = 2'b01,
    BT_RSV  = 2'b10,
    BT_RW   = 2'b11
  } bp_type_e;

  typedef struct packed {
    logic       en;
    bp_type_e   kind;
    logic [1:0] len;
  } bp_cfg_t;
endpackage

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP = 4,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  localparam int unsigned STAT_W = NUM_BP + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [STAT_W-1:0]    set_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NUM_BP*AW-1:0] addr_o,
  output logic [DW-1:0]        ctrl_o,
  output logic [STAT_W-1:0]    stat_o
);
  logic [AW-1:0] addr_q [NUM_BP];
  logic [DW-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_q[i] <= '0;
      else if (we_i && sel_i == SEL_W'(i)) addr_q[i] <= wdata_i[AW-1:0];
    end
    assign addr_o[i*AW +: AW] = addr_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_CTRL) ctrl_q <= wdata_i;
      // new hits are ORed after a software write so none is lost
      stat_q <= ((we_i && sel_i == SEL_STAT) ? wdata_i[STAT_W-1:0] : stat_q) | set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_STAT) rdata_o = DW'(stat_q);
    else if (sel_i == SEL_CTRL) rdata_o = ctrl_q;
    else begin
      for (int i = 0; i < NUM_BP; i++)
        if (sel_i == SEL_W'(i)) rdata_o = DW'(addr_q[i]);
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/dbg_match.sv
module dbg_match
  import dbg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  bp_cfg_t       cfg_i,
  input  logic [AW-1:0] bp_addr_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          data_valid_i,
  input  logic          data_we_i,
  input  logic [AW-1:0] data_addr_i,
  output logic          exec_hit_o,
  output logic          data_hit_o
);
  logic [AW-1:0] mask;
  logic          kind_ok;

  always_comb begin
    unique case (cfg_i.len)
      2'b00:   mask = '1;
      2'b01:   mask = {{(AW-1){1'b1}}, 1'b0};
      default: mask = {{(AW-2){1'b1}}, 2'b00};
    endcase
  end

  assign kind_ok    = (cfg_i.kind == BT_RW) || (cfg_i.kind == BT_WR && data_we_i);
  assign exec_hit_o = cfg_i.en && cfg_i.kind == BT_EXEC && fetch_valid_i
                      && fetch_addr_i == bp_addr_i;
  assign data_hit_o = cfg_i.en && data_valid_i && kind_ok
                      && ((data_addr_i ^ bp_addr_i) & mask) == '0;
endmodule

// File: rtl/dbg_trap_unit.sv
module dbg_trap_unit
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_BP   = 4,
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned STEP_BIT = 8,
  parameter logic [7:0]  BRK_OPC  = 8'hCC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             fetch_valid_i,
  input  logic [AW-1:0]    fetch_addr_i,
  input  logic [7:0]       fetch_opcode_i,
  input  logic             data_valid_i,
  input  logic             data_we_i,
  input  logic [AW-1:0]    data_addr_i,
  input  logic             retire_valid_i,
  input  logic [DW-1:0]    retire_flags_i,
  output logic             exc_req_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic             exc_fault_o
);
  localparam int unsigned STAT_W = NUM_BP + 1;
  localparam int unsigned CFG_MSB = CFG_LSB + CFG_PITCH * NUM_BP - 1;

  logic [NUM_BP*AW-1:0] bp_addr;
  logic [DW-1:0]        ctrl;
  logic [STAT_W-1:0]    stat_q;
  logic [NUM_BP-1:0]    exec_hit, data_hit, bp_hit;
  logic                 step_hit, brk_hit, dbg_any;
  logic                 unused_bits;

  assign unused_bits = ^{retire_flags_i, ctrl[DW-1:CFG_MSB+1], ctrl[CFG_LSB-1:NUM_BP]};

  dbg_regs #(.NUM_BP(NUM_BP), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i   (reg_we_i),
    .sel_i  (reg_sel_i),
    .wdata_i(reg_wdata_i),
    .set_i  ({step_hit, bp_hit}),
    .rdata_o(reg_rdata_o),
    .addr_o (bp_addr),
    .ctrl_o (ctrl),
    .stat_o (stat_q)
  );

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    bp_cfg_t cfg;
    assign cfg.en   = ctrl[i];
    assign cfg.kind = bp_type_e'(ctrl[CFG_LSB + CFG_PITCH*i +: 2]);
    assign cfg.len  = ctrl[CFG_LSB + CFG_PITCH*i + 2 +: 2];

    dbg_match #(.AW(AW)) u_match (
      .cfg_i        (cfg),
      .bp_addr_i    (bp_addr[i*AW +: AW]),
      .fetch_valid_i,
      .fetch_addr_i,
      .data_valid_i,
      .data_we_i,
      .data_addr_i,
      .exec_hit_o   (exec_hit[i]),
      .data_hit_o   (data_hit[i])
    );
    assign bp_hit[i] = exec_hit[i] | data_hit[i];
  end

  assign step_hit = retire_valid_i && retire_flags_i[STEP_BIT];
  assign brk_hit  = fetch_valid_i && fetch_opcode_i == BRK_OPC;
  assign dbg_any  = |bp_hit || step_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_req_o   <= 1'b0;
      exc_vec_o   <= '0;
      exc_fault_o <= 1'b0;
    end else begin
      exc_req_o   <= dbg_any || brk_hit;
      exc_vec_o   <= dbg_any ? VEC_DBG : (brk_hit ? VEC_BRK : '0);
      exc_fault_o <= |exec_hit;
    end
  end
endmodule

// File: rtl/dbg_trap_chk.sv
module dbg_trap_chk #(
  parameter int unsigned STAT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic              fetch_valid_i,
  input logic [7:0]        fetch_opcode_i,
  input logic              data_valid_i,
  input logic              retire_valid_i,
  input logic [31:0]       retire_flags_i,
  input logic              exc_req_o,
  input logic [7:0]        exc_vec_o,
  input logic              exc_fault_o,
  input logic [STAT_W-1:0] stat_q
);
  // R6
  req_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> $past(fetch_valid_i || data_valid_i || retire_valid_i));

  // R7
  step_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_i && retire_flags_i[8] |=> exc_req_o && exc_vec_o == 8'd1);

  // R8
  brk_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_opcode_i == 8'hCC |=> exc_req_o);

  // R9
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_vec_o == 8'd1 || exc_vec_o == 8'd3));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_req_o |-> (exc_vec_o == 8'd0 && !exc_fault_o));

  // R3
  fault_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fault_o |-> (exc_req_o && exc_vec_o == 8'd1));

  // R10
  sticky_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_sel_i == 3'd4) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

bind dbg_trap_unit dbg_trap_chk #(.STAT_W(NUM_BP + 1)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_sel_i     (reg_sel_i),
  .fetch_valid_i (fetch_valid_i),
  .fetch_opcode_i(fetch_opcode_i),
  .data_valid_i  (data_valid_i),
  .retire_valid_i(retire_valid_i),
  .retire_flags_i(retire_flags_i),
  .exc_req_o     (exc_req_o),
  .exc_vec_o     (exc_vec_o),
  .exc_fault_o   (exc_fault_o),
  .stat_q        (stat_q)
);

// File: tb/dbg_trap_unit_test.sv
`timescale 1ns/1ps
module dbg_trap_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic [7:0]  fetch_opcode_i = '0;
  logic        data_valid_i = 1'b0;
  logic        data_we_i = 1'b0;
  logic [31:0] data_addr_i = '0;
  logic        retire_valid_i = 1'b0;
  logic [31:0] retire_flags_i = '0;
  logic        exc_req_o;
  logic [7:0]  exc_vec_o;
  logic        exc_fault_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk_i = ~clk_i;

  dbg_trap_unit uut (.*);

  // reference model
  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl;
  logic [4:0]  m_stat;
  logic        m_req, m_fault;
  logic [7:0]  m_vec;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) m_addr[i] <= 0;
      m_ctrl <= 0; m_stat <= 0; m_req <= 0; m_vec <= 0; m_fault <= 0;
    end else begin
      automatic logic [3:0] hits = 0;
      automatic bit exe = 0;
      automatic bit stp = retire_valid_i && retire_flags_i[8];
      automatic bit brk = fetch_valid_i && fetch_opcode_i == 8'hCC;
      automatic logic [4:0] ns;
      cycles <= cycles + 1;
      for (int i = 0; i < 4; i++) begin
        automatic int ty = (m_ctrl >> (8 + 4*i)) & 3;
        automatic int ln = (m_ctrl >> (10 + 4*i)) & 3;
        automatic longint gran = (ln == 0) ? 1 : (ln == 1) ? 2 : 4;
        if (m_ctrl[i]) begin
          if (ty == 0 && fetch_valid_i && fetch_addr_i == m_addr[i]) begin
            hits[i] = 1; exe = 1;
          end
          if (data_valid_i && (ty == 3 || (ty == 1 && data_we_i))
              && (longint'(data_addr_i) / gran) == (longint'(m_addr[i]) / gran))
            hits[i] = 1;
        end
      end
      ns = (reg_we_i && reg_sel_i == 4) ? reg_wdata_i[4:0] : m_stat;
      m_stat <= ns | {stp, hits};
      if (reg_we_i && reg_sel_i < 4) m_addr[reg_sel_i] <= reg_wdata_i;
      if (reg_we_i && reg_sel_i == 5) m_ctrl <= reg_wdata_i;
      m_req   <= (hits != 0) || stp || brk;
      m_vec   <= ((hits != 0) || stp) ? 8'd1 : (brk ? 8'd3 : 8'd0);
      m_fault <= exe;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] s);
    if (s < 4) return m_addr[s];
    if (s == 4) return {27'd0, m_stat};
    if (s == 5) return m_ctrl;
    return 0;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // advance one clock, then compare everything at mid-low phase
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    #1;
    chk("exc_req", 32'(exc_req_o), 32'(m_req));
    chk("exc_vec", 32'(exc_vec_o), 32'(m_vec));
    chk("exc_fault", 32'(exc_fault_o), 32'(m_fault));
    chk("rdata", reg_rdata_o, m_read(reg_sel_i));
  endtask

  task automatic idle();
    reg_we_i = 0; fetch_valid_i = 0; data_valid_i = 0; data_we_i = 0;
    retire_valid_i = 0; retire_flags_i = 0; fetch_opcode_i = 8'h90;
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we_i = 1; reg_sel_i = s; reg_wdata_i = d;
    tick();
    reg_we_i = 0; reg_sel_i = 3'd4;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [7:0] op);
    fetch_valid_i = 1; fetch_addr_i = a; fetch_opcode_i = op;
    tick(); idle(); tick();
  endtask

  task automatic dacc(input logic [31:0] a, input bit w);
    data_valid_i = 1; data_addr_i = a; data_we_i = w;
    tick(); idle(); tick();
  endtask

  function automatic logic [31:0] cfg(input int i, input int ty, input int ln);
    return (32'(1) << i) | (32'(ty) << (8 + 4*i)) | (32'(ln) << (10 + 4*i));
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog %s actual=timeout expected=done", cur_req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    #12;
    @(negedge clk_i);
    rst_ni = 1;
    // R1: reset state of every register and output
    cur_req = "R1";
    for (int s = 0; s < 8; s++) begin reg_sel_i = 3'(s); tick(); end

    // R2: register map and unused selects
    cur_req = "R2";
    wr(0, 32'h0000_1000); wr(1, 32'h0000_2004);
    wr(2, 32'h0000_3001); wr(3, 32'h0000_4000);
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hA5A5_A5A5);
    for (int s = 0; s < 8; s++) begin reg_sel_i = 3'(s); tick(); end
    reg_sel_i = 4;

    // R6: fields set but enables clear
    cur_req = "R6";
    wr(5, cfg(0, 0, 0) & ~32'h1 | 32'h0000_FF00);
    fetch(32'h1000, 8'h90); dacc(32'h2004, 1); dacc(32'h4000, 0);

    // R3: execute breakpoint is a fault, exact address only
    cur_req = "R3";
    wr(5, cfg(0, 0, 0));
    fetch(32'h1000, 8'h90); fetch(32'h1001, 8'h90); fetch(32'h0FFF, 8'h90);
    dacc(32'h1000, 1);

    // R4: data types
    cur_req = "R4";
    wr(4, 0);
    wr(5, cfg(1, 1, 3) | cfg(2, 3, 0) | cfg(3, 2, 3));
    dacc(32'h2004, 0); dacc(32'h2004, 1); dacc(32'h3001, 0); dacc(32'h3001, 1);
    dacc(32'h4000, 0); dacc(32'h4000, 1); fetch(32'h2004, 8'h90);

    // R5: length masks
    cur_req = "R5";
    wr(4, 0); wr(0, 32'h0000_5002);
    wr(5, cfg(0, 3, 0));
    dacc(32'h5002, 0); dacc(32'h5003, 0);
    wr(5, cfg(0, 3, 1));
    dacc(32'h5003, 0); dacc(32'h5001, 0); dacc(32'h5004, 0);
    wr(5, cfg(0, 3, 3));
    dacc(32'h5000, 0); dacc(32'h5003, 1); dacc(32'h5004, 1); dacc(32'h4FFF, 0);
    wr(5, cfg(0, 3, 2));
    dacc(32'h5001, 0); dacc(32'h5004, 0);

    // R7: single-step
    cur_req = "R7";
    wr(4, 0); wr(5, 0);
    retire_valid_i = 1; retire_flags_i = 32'h0000_0100; tick(); idle(); tick();
    retire_valid_i = 1; retire_flags_i = 32'hFFFF_FEFF; tick(); idle(); tick();
    retire_valid_i = 0; retire_flags_i = 32'h0000_0100; tick(); idle(); tick();

    // R8: software breakpoint opcode
    cur_req = "R8";
    wr(4, 0);
    fetch(32'h8000, 8'hCC); fetch(32'h8000, 8'hCD);
    fetch_valid_i = 0; fetch_opcode_i = 8'hCC; tick(); idle(); tick();

    // R9: coincident conditions
    cur_req = "R9";
    wr(0, 32'h0000_9000); wr(1, 32'h0000_A000);
    wr(5, cfg(0, 0, 0) | cfg(1, 3, 3));
    fetch_valid_i = 1; fetch_addr_i = 32'h9000; fetch_opcode_i = 8'hCC;
    data_valid_i = 1; data_addr_i = 32'hA002; data_we_i = 0;
    retire_valid_i = 1; retire_flags_i = 32'h100;
    tick(); idle(); tick();
    fetch_valid_i = 1; fetch_addr_i = 32'h7000; fetch_opcode_i = 8'hCC;
    data_valid_i = 1; data_addr_i = 32'hA001;
    tick(); idle(); tick();
    fetch_valid_i = 1; fetch_addr_i = 32'h7000; fetch_opcode_i = 8'hCC;
    retire_valid_i = 1; retire_flags_i = 32'h100;
    tick(); idle(); tick();

    // R10: sticky status, write clears, same-cycle hit survives
    cur_req = "R10";
    wr(4, 5'h1F); tick(); tick();
    wr(4, 0);
    reg_we_i = 1; reg_sel_i = 4; reg_wdata_i = 0;
    fetch_valid_i = 1; fetch_addr_i = 32'h9000;
    tick(); idle(); reg_sel_i = 4; tick(); tick();
    wr(4, 32'h0000_0004); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule